// File: doc/BRIEF.md
# Multi-Level Page Table Walker

The walker turns a virtual address into a physical page base. It reads page-table entries one at a time through a single memory port, starting at a root page and going down one level per entry. The entry format is picked for each walk: a 32-bit layout with two levels, or a 64-bit layout with three or four levels. The caller gives the virtual address, the access kind (load, store or fetch), a supervisor flag, a user-protect flag and the root page number. It then waits for a one-cycle completion pulse that carries either a page base or a fault.

A walk rejects a non-canonical address before it reads any memory. It follows pointer entries, checks the leaf against the access kind and privilege, and writes the entry back with the accessed bit set (and the dirty bit set for stores) before it reports success. A leaf found above the last level maps a large page. The result is then the entry's page number with the low virtual page bits of the skipped levels OR'd in. The fault is a separate flag, so a page base of any value can never be read as a fault.

Top module: `pt_walker`

## Requirements
- R1: `fmt_i` picks the layout. 0 means two levels, 10 index bits per level, 4-byte entries, only `va_i[31:0]` used and the entry taken from `mem_rdata_i[31:0]`. 1 means three levels, 9 index bits, 8-byte entries. 2 means four levels, 9 index bits, 8-byte entries. 3 faults with no memory access.
- R2: For formats 1 and 2 the address width W is 12 + levels*9. If `va_i[63:W-1]` is neither all zeros nor all ones, `done_o` and `fault_o` are high in the cycle after the start edge and no memory request is made.
- R3: The first entry address is root<<12 plus the top index field times the entry size. Later addresses use the lower index fields in order. Each request is a one-cycle `mem_req_o` pulse.
- R4: A memory response with `mem_err_i` high during an entry read ends the walk with a fault.
- R5: An entry with V (bit 0) = 1 and R, W, X (bits 1, 2, 3) all zero is a pointer. The next base is (entry>>10)<<12, and the walk goes down one level.
- R6: An entry with V = 0 faults. A pointer at the last level faults.
- R7: A leaf needs R for a load (`acc_i` 0 or 3), W for a store (`acc_i` 1) and X for a fetch (`acc_i` 2). With `sup_i` low it also needs U (bit 4). Otherwise it faults.
- R8: With `uprot_i` high, a leaf that has U set and the bit this access needs faults, even when `sup_i` is high.
- R9: A granted leaf is written back at its own address, same entry size, with A (bit 6) set, and D (bit 7) set as well for stores. No other walk writes memory. An error on the write-back faults.
- R10: On success `ppage_o` = ((entry>>10) | (vpn & ((1<<(lvl*idx_bits))-1)))<<12, where lvl is the number of levels left below the leaf.
- R11: `done_o` is a one-cycle pulse. `ppage_o` is 0 when `fault_o` is high. Results hold until the next start. `start_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted when idle) |
| fmt_i | input | 2 | Table format select |
| acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| sup_i | input | 1 | Access is made in supervisor mode |
| uprot_i | input | 1 | Forbid supervisor access to user pages |
| va_i | input | 64 | Virtual address |
| root_i | input | 52 | Root table page number |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk failed |
| ppage_o | output | 64 | Physical page base |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | Request is a write-back |
| mem_wide_o | output | 1 | Entry is 8 bytes (else 4) |
| mem_addr_o | output | 64 | Entry address |
| mem_wdata_o | output | 64 | Write-back entry |
| mem_ack_i | input | 1 | Memory response strobe |
| mem_err_i | input | 1 | Address is not valid memory |
| mem_rdata_i | input | 64 | Entry read data |

## Verification
The bench aims at large-page leaves, where a walker that replaced the page bits instead of OR'ing them, or that used the wrong level's mask, would return a wrong base. It mixes accesses with and without U under user-protect, so that a design granting supervisor access to protected pages, or refusing legal ones, is exposed. It checks the write-back value and count, which catches a missing dirty bit, a write on a failed walk, or a 4-byte entry written as 8 bytes. It sends addresses one bit off canonical and the reserved format, so any memory traffic before the fault shows up. It also sends a start while a walk is running, which a design that does not ignore it would act on.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam logic [1:0] FMT_W32L2 = 2'd0;
  localparam logic [1:0] FMT_W64L3 = 2'd1;
  localparam logic [1:0] FMT_W64L4 = 2'd2;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;

  localparam int IDX_N32 = 10;
  localparam int IDX_N64 = 9;
  localparam int LVL_N32 = 2;
  localparam int LVL_N64S = 3;
  localparam int LVL_N64L = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WAIT, ST_WB, ST_WB_WAIT, ST_DONE
  } ptw_state_e;
endpackage

// File: rtl/ptw_fmt_decode.sv
module ptw_fmt_decode
  import ptw_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12
) (
  input  logic [1:0]      fmt_i,
  input  logic [XLEN-1:0] va_i,
  output logic [2:0]      levels_o,
  output logic [3:0]      idx_bits_o,
  output logic            wide_o,
  output logic            fmt_ok_o,
  output logic            canon_o
);
  logic [XLEN-1:0] hi, msk;
  int vab;

  always_comb begin
    fmt_ok_o = 1'b1;
    unique case (fmt_i)
      FMT_W32L2: begin levels_o = 3'(LVL_N32);  idx_bits_o = 4'(IDX_N32); wide_o = 1'b0; end
      FMT_W64L3: begin levels_o = 3'(LVL_N64S); idx_bits_o = 4'(IDX_N64); wide_o = 1'b1; end
      FMT_W64L4: begin levels_o = 3'(LVL_N64L); idx_bits_o = 4'(IDX_N64); wide_o = 1'b1; end
      default:   begin levels_o = 3'd1; idx_bits_o = 4'(IDX_N64); wide_o = 1'b1; fmt_ok_o = 1'b0; end
    endcase
  end

  // upper bits from width-1 upward must all match
  always_comb begin
    vab     = PG_SHIFT + int'(levels_o) * int'(idx_bits_o);
    hi      = va_i >> (vab - 1);
    msk     = {XLEN{1'b1}} >> (vab - 1);
    canon_o = !wide_o || (hi == '0) || (hi == msk);
  end
endmodule

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int LVL_W    = 2
) (
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [3:0]       idx_bits_i,
  input  logic             wide_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [XLEN-1:0]  low_vpn_o
);
  int below;
  logic [XLEN-1:0] idx;

  always_comb begin
    below     = int'(lvl_i) * int'(idx_bits_i);
    idx       = (va_i >> (PG_SHIFT + below)) & ((XLEN'(1) << idx_bits_i) - XLEN'(1));
    addr_o    = base_i + (wide_i ? (idx << 3) : (idx << 2));
    low_vpn_o = (va_i >> PG_SHIFT) & ((XLEN'(1) << below) - XLEN'(1));
  end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic [4:0] flags_i,
  input  logic [1:0] acc_i,
  input  logic       sup_i,
  input  logic       uprot_i,
  output logic       valid_o,
  output logic       ptr_o,
  output logic       grant_o
);
  logic kind_ok, pum_hit, priv_ok;

  always_comb begin
    valid_o = flags_i[B_V];
    ptr_o   = flags_i[B_V] && !flags_i[B_R] && !flags_i[B_W] && !flags_i[B_X];
    unique case (acc_i)
      ACC_STORE: kind_ok = flags_i[B_W];
      ACC_FETCH: kind_ok = flags_i[B_X];
      default:   kind_ok = flags_i[B_R];
    endcase
    pum_hit = uprot_i && flags_i[B_U] && kind_ok;
    priv_ok = sup_i || flags_i[B_U];
    grant_o = kind_ok && priv_ok && !pum_hit;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int PG_SHIFT = 12,
  parameter int PPN_LSB  = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [1:0]           fmt_i,
  input  logic [1:0]           acc_i,
  input  logic                 sup_i,
  input  logic                 uprot_i,
  input  logic [XLEN-1:0]      va_i,
  input  logic [XLEN-PG_SHIFT-1:0] root_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 fault_o,
  output logic [XLEN-1:0]      ppage_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic                 mem_wide_o,
  output logic [XLEN-1:0]      mem_addr_o,
  output logic [XLEN-1:0]      mem_wdata_o,
  input  logic                 mem_ack_i,
  input  logic                 mem_err_i,
  input  logic [XLEN-1:0]      mem_rdata_i
);
  localparam int LVL_W = 2;

  ptw_state_e state_q;
  logic [1:0]       fmt_q, acc_q;
  logic             sup_q, uprot_q, fault_q;
  logic [XLEN-1:0]  va_q, base_q, pte_q, ppage_q;
  logic [LVL_W-1:0] lvl_q;

  logic             idle;
  logic [1:0]       fmt_sel;
  logic [XLEN-1:0]  va_sel;
  logic [2:0]       levels;
  logic [3:0]       idx_bits;
  logic             wide, fmt_ok, canon;
  logic [XLEN-1:0]  ent_addr, low_vpn, pte_rd, ppn_rd;
  logic             pte_valid, pte_ptr, pte_grant;

  assign idle    = (state_q == ST_IDLE);
  assign fmt_sel = idle ? fmt_i : fmt_q;
  assign va_sel  = idle ? va_i : va_q;

  ptw_fmt_decode #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT)) u_dec (
    .fmt_i(fmt_sel), .va_i(va_sel), .levels_o(levels), .idx_bits_o(idx_bits),
    .wide_o(wide), .fmt_ok_o(fmt_ok), .canon_o(canon)
  );

  ptw_index #(.XLEN(XLEN), .PG_SHIFT(PG_SHIFT), .LVL_W(LVL_W)) u_idx (
    .base_i(base_q), .va_i(va_q), .lvl_i(lvl_q), .idx_bits_i(idx_bits),
    .wide_i(wide), .addr_o(ent_addr), .low_vpn_o(low_vpn)
  );

  // narrow entries ignore the upper half of the read data
  assign pte_rd = wide ? mem_rdata_i : {{(XLEN-32){1'b0}}, mem_rdata_i[31:0]};
  assign ppn_rd = pte_rd >> PPN_LSB;

  ptw_pte_check u_chk_pte (
    .flags_i(pte_rd[4:0]), .acc_i(acc_q), .sup_i(sup_q), .uprot_i(uprot_q),
    .valid_o(pte_valid), .ptr_o(pte_ptr), .grant_o(pte_grant)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fmt_q   <= '0;
      acc_q   <= '0;
      sup_q   <= 1'b0;
      uprot_q <= 1'b0;
      va_q    <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      ppage_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          fmt_q   <= fmt_i;
          acc_q   <= acc_i;
          sup_q   <= sup_i;
          uprot_q <= uprot_i;
          va_q    <= va_i;
          base_q  <= XLEN'(root_i) << PG_SHIFT;
          lvl_q   <= LVL_W'(levels - 3'd1);
          ppage_q <= '0;
          if (!fmt_ok || !canon) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            fault_q <= 1'b0;
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_WAIT;
        ST_WAIT: if (mem_ack_i) begin
          pte_q <= pte_rd;
          if (mem_err_i || !pte_valid) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (pte_ptr) begin
            if (lvl_q == '0) begin
              fault_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              base_q  <= ppn_rd << PG_SHIFT;
              lvl_q   <= lvl_q - 1'b1;
              state_q <= ST_READ;
            end
          end else if (!pte_grant) begin
            fault_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            ppage_q <= (ppn_rd | low_vpn) << PG_SHIFT;
            state_q <= ST_WB;
          end
        end
        ST_WB: state_q <= ST_WB_WAIT;
        ST_WB_WAIT: if (mem_ack_i) begin
          if (mem_err_i) begin
            fault_q <= 1'b1;
            ppage_q <= '0;
          end
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = fault_q;
  assign ppage_o     = ppage_q;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WB);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_wide_o  = wide;
  assign mem_addr_o  = ent_addr;
  assign mem_wdata_o = pte_q | (XLEN'(1) << B_A) | (XLEN'(acc_q == ACC_STORE) << B_D);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [1:0]      fmt_i,
  input logic [XLEN-1:0] va_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            fault_o,
  input logic [XLEN-1:0] ppage_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic            mem_wide_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic [XLEN-1:0] mem_wdata_o
);
  localparam int TOP3 = 12 + 3 * 9 - 1;
  localparam int TOP4 = 12 + 4 * 9 - 1;

  logic bad_va;
  always_comb begin
    bad_va = 1'b0;
    if (fmt_i == 2'd1) bad_va = !((&va_i[XLEN-1:TOP3]) || !(|va_i[XLEN-1:TOP3]));
    if (fmt_i == 2'd2) bad_va = !((&va_i[XLEN-1:TOP4]) || !(|va_i[XLEN-1:TOP4]));
  end

  p_noncanon_fault_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && bad_va) |=> (done_o && fault_o && !mem_req_o));

  p_reserved_fmt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && fmt_i == 2'd3) |=> (done_o && fault_o));

  p_req_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_wide_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_wide_o) |-> (mem_addr_o[2:0] == 3'd0));

  p_wb_accessed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[6]);

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (ppage_o == '0));

  p_page_aligned_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ppage_o[11:0] == 12'd0));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN)) u_walk_chk (.*);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam int MEM_WORDS = 8192;
  localparam logic [63:0] MEM_BYTES = 64'd65536;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, sup_i = 1'b0, uprot_i = 1'b0;
  logic [1:0] fmt_i = '0, acc_i = '0;
  logic [63:0] va_i = '0;
  logic [51:0] root_i = '0;
  logic busy_o, done_o, fault_o, mem_req_o, mem_we_o, mem_wide_o;
  logic [63:0] ppage_o, mem_addr_o, mem_wdata_o;
  logic mem_ack_i = 1'b0, mem_err_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  pt_walker u_pt_walker (.*);

  always #2 clk_i = ~clk_i;

  logic [63:0] mem [MEM_WORDS];
  int n_tests = 0, n_fail = 0, n_reads = 0, n_writes = 0, cyc = 0;

  // memory responder, driven away from the active edge
  logic pend = 1'b0, p_we, p_wide;
  logic [63:0] p_addr, p_wdata;
  int p_cnt = 0;
  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    mem_ack_i = 1'b0;
    mem_err_i = 1'b0;
    if (pend) begin
      p_cnt = p_cnt - 1;
      if (p_cnt == 0) begin
        pend = 1'b0;
        mem_ack_i = 1'b1;
        if (p_addr >= MEM_BYTES) mem_err_i = 1'b1;
        else if (p_we) begin
          n_writes++;
          if (p_wide) mem[p_addr[15:3]] = p_wdata;
          else if (p_addr[2]) mem[p_addr[15:3]][63:32] = p_wdata[31:0];
          else mem[p_addr[15:3]][31:0] = p_wdata[31:0];
        end else begin
          if (p_wide) mem_rdata_i = mem[p_addr[15:3]];
          else mem_rdata_i = {$urandom(), p_addr[2] ? mem[p_addr[15:3]][63:32]
                                                    : mem[p_addr[15:3]][31:0]};
        end
      end
    end else if (mem_req_o) begin
      pend = 1'b1; p_we = mem_we_o; p_wide = mem_wide_o;
      p_addr = mem_addr_o; p_wdata = mem_wdata_o;
      p_cnt = 1 + int'($urandom() % 3);
      if (!mem_we_o) n_reads++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_ent(input logic [63:0] a, input bit wide);
    logic [63:0] w = mem[a[15:3]];
    if (wide) return w;
    return a[2] ? {32'd0, w[63:32]} : {32'd0, w[31:0]};
  endfunction

  // reference walk from the requirements
  task automatic model(input logic [1:0] fmt, input logic [63:0] va, input logic [1:0] acc,
                       input bit sup, input bit up, input logic [51:0] root,
                       output bit flt, output logic [63:0] pg, output int rds,
                       output bit wb, output logic [63:0] wa, output logic [63:0] wv);
    int lv, ib, vab;
    bit wide;
    logic [63:0] base, a, pte, hi, msk;
    bit kind;
    flt = 1'b1; pg = '0; rds = 0; wb = 1'b0; wa = '0; wv = '0;
    case (fmt)
      2'd0: begin lv = 2; ib = 10; wide = 0; end
      2'd1: begin lv = 3; ib = 9; wide = 1; end
      2'd2: begin lv = 4; ib = 9; wide = 1; end
      default: return;
    endcase
    if (wide) begin
      vab = 12 + lv * ib;
      hi = va >> (vab - 1);
      msk = ~64'd0 >> (vab - 1);
      if (hi != 0 && hi != msk) return;
    end
    base = {12'd0, root} << 12;
    for (int i = lv - 1; i >= 0; i--) begin
      a = base + (((va >> (12 + i * ib)) & ((64'd1 << ib) - 1)) * (wide ? 8 : 4));
      rds++;
      if (a >= MEM_BYTES) return;
      pte = rd_ent(a, wide);
      if (!pte[0]) return;
      if (pte[3:1] == 3'b000) begin
        base = (pte >> 10) << 12;
        continue;
      end
      kind = (acc == 2'd1) ? pte[2] : (acc == 2'd2) ? pte[3] : pte[1];
      if (!kind || (!sup && !pte[4]) || (up && pte[4])) return;
      wb = 1'b1; wa = a;
      wv = pte | 64'h40 | ((acc == 2'd1) ? 64'h80 : 64'h0);
      if (!wide) wv = {32'd0, wv[31:0]};
      pg = ((pte >> 10) | ((va >> 12) & ((64'd1 << (i * ib)) - 1))) << 12;
      flt = 1'b0;
      return;
    end
  endtask

  task automatic walk(input logic [1:0] fmt, input logic [63:0] va, input logic [1:0] acc,
                      input bit sup, input bit up, input logic [51:0] root, input bit glitch,
                      input string tag);
    bit ef, ewb;
    logic [63:0] ep, ewa, ewv;
    int er;
    model(fmt, va, acc, sup, up, root, ef, ep, er, ewb, ewa, ewv);
    n_reads = 0; n_writes = 0;
    fmt_i = fmt; va_i = va; acc_i = acc; sup_i = sup; uprot_i = up; root_i = root;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (glitch && !done_o) begin
      start_i = 1'b1; fmt_i = 2'd3; va_i = ~va;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o && cyc < 150000) @(negedge clk_i);
    chk(fault_o == ef, {tag, " fault"}, 64'(fault_o), 64'(ef));
    chk(ppage_o == ep, {tag, " page"}, ppage_o, ep);
    chk(n_reads == er, {tag, " reads"}, 64'(n_reads), 64'(er));
    chk(n_writes == int'(ewb), {tag, " writes R9"}, 64'(n_writes), 64'(ewb));
    if (ewb) chk(rd_ent(ewa, fmt != 0) == ewv, {tag, " wb value R9"}, rd_ent(ewa, fmt != 0), ewv);
    @(negedge clk_i);
  endtask

  function automatic logic [9:0] rnd_flags();
    logic [9:0] f = 10'($urandom());
    f[0] = ($urandom() % 8) != 0;
    if ($urandom() % 2) f[3:1] = 3'b000;
    return f;
  endfunction

  task automatic fill(input bit wide);
    for (int i = 0; i < MEM_WORDS; i++) begin
      if (wide) mem[i] = (64'($urandom() % 18) << 10) | 64'(rnd_flags());
      else mem[i] = {22'($urandom() % 18), rnd_flags(), 22'($urandom() % 18), rnd_flags()};
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(negedge clk_i);
      if (cyc >= 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !busy_o && !mem_req_o, "R11 reset idle", {61'd0, done_o, busy_o, mem_req_o}, 64'd0);
    chk(ppage_o == 0 && !fault_o, "R11 reset result", ppage_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: non-canonical, fault next cycle, no reads
    fmt_i = 2'd1; va_i = 64'h0000_0040_0000_0000; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(done_o && fault_o, "R2 immediate fault", {62'd0, done_o, fault_o}, 64'd3);
    @(negedge clk_i);
    walk(2'd2, 64'hFFFF_0000_0000_0000, 2'd0, 1, 0, 52'd1, 0, "R2 4-level noncanon");
    walk(2'd3, 64'h1000, 2'd0, 1, 0, 52'd1, 0, "R1 reserved fmt");

    // R10: 3-level large page at top level
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    mem[64'h1000 >> 3] = (64'h40000 << 10) | 64'h3;
    walk(2'd1, 64'h0000_0000_0012_3456, 2'd0, 1, 0, 52'd1, 0, "R10 superpage");
    chk(ppage_o == 64'h4012_3000, "R10 composed base", ppage_o, 64'h4012_3000);
    chk(mem[64'h1000 >> 3] == ((64'h40000 << 10) | 64'h43), "R9 A set on load",
        mem[64'h1000 >> 3], (64'h40000 << 10) | 64'h43);

    // R5/R9: 2-level narrow pointer then user store leaf
    mem[64'h2000 >> 3] = {32'd0, 22'd3, 10'h001} << 32;
    mem[64'h3000 >> 3] = {32'd0, 22'd5, 10'h017} << 32;
    walk(2'd0, 64'hABCD_0000_0040_1000, 2'd1, 0, 0, 52'd2, 0, "R5 narrow pointer");
    chk(ppage_o == 64'h5000, "R5 leaf base", ppage_o, 64'h5000);
    chk(mem[64'h3000 >> 3] == {22'd5, 10'h0D7, 32'd0}, "R9 dirty narrow",
        mem[64'h3000 >> 3], {22'd5, 10'h0D7, 32'd0});
    // R8: user-protect forbids supervisor load of user page
    walk(2'd0, 64'h0040_1000, 2'd0, 1, 1, 52'd2, 0, "R8 protect");
    chk(fault_o, "R8 protect fault", 64'(fault_o), 64'd1);
    // R7: user access to supervisor page
    mem[64'h3000 >> 3] = {22'd5, 10'h003, 32'd0};
    walk(2'd0, 64'h0040_1000, 2'd0, 0, 0, 52'd2, 0, "R7 no U");
    // R4: root outside memory
    walk(2'd1, 64'h1000, 2'd0, 1, 0, 52'h100, 0, "R4 mem error");
    // R6: pointer at last level
    mem[64'h2000 >> 3] = {32'd0, 22'd3, 10'h001} << 32;
    mem[64'h3000 >> 3] = {22'd5, 10'h001, 32'd0};
    walk(2'd0, 64'h0040_1000, 2'd0, 1, 0, 52'd2, 0, "R6 out of levels");
    // R11: start during busy ignored
    walk(2'd1, 64'h0000_0000_0012_3456, 2'd0, 1, 0, 52'd1, 1, "R11 busy start");

    for (int t = 0; t < 300; t++) begin
      logic [1:0] f;
      logic [63:0] va;
      int vab;
      f = ($urandom() % 10 == 0) ? 2'd3 : 2'($urandom() % 3);
      fill(f != 2'd0);
      va = {$urandom(), $urandom()};
      if (f != 2'd0 && f != 2'd3 && ($urandom() % 4) != 0) begin
        vab = (f == 2'd1) ? 39 : 48;
        va = va[vab-1] ? (va | (~64'd0 << vab)) : (va & ~(~64'd0 << vab));
      end
      walk(f, va, 2'($urandom()), 1'($urandom()), 1'($urandom()),
           52'($urandom() % 18), ($urandom() % 8) == 0, "R1 R3 R7 R10 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule